// File: doc/BRIEF.md
# Multi-rate Electrical Link Transmitter Group

This block spreads a 16-bit data slice, presented once per 40 MHz frame, across a group of up to eight serial electrical links toward a frontend. A configuration input picks one of three per-link rates. At 80 Mb/s all eight links each carry 2 bits per frame. At 160 Mb/s four links each carry 4 bits. At 320 Mb/s two links each carry 8 bits. The bit budget per frame is therefore the same at every setting. Each link drives a serial data output together with a forwarded bit clock. Both are derived from a fast reference clock that runs 16 times the frame rate.

Links can also be bonded into lanes of 2, 4 or 8 members to carry more than 320 Mb/s toward one destination. The bits of a lane's share of the slice are then dealt out round-robin over its members. The rate, the bonding and the slice are all taken at a frame strobe and held for the full frame. Configuration can therefore be written at any time without corrupting a frame in flight.

Top module: `elink_tx_group`

## Requirements
- R1: After reset and until the first frame strobe, every link data output and every forwarded clock output is low.
- R2: The rate code selects the link layout. Code 0 gives 8 active links of 2 bits each. Code 1 gives 4 links of 4 bits. Code 2 gives 2 links of 8 bits. Code 3 behaves exactly like code 0.
- R3: The reference clock runs 16 cycles per frame. A bit slot lasts 8, 4 or 2 cycles for codes 0, 1 and 2. The first slot starts in the cycle that follows the clock edge at which the strobe is high. Each link sends its bits most-significant first, and data changes only where link 0's clock rises.
- R4: Without bonding, active link i carries the slice bits from index 15-i*B down to 16-(i+1)*B, where B is the bits per link.
- R5: On an active link the forwarded clock is high for the first half of every bit slot and low for the second half.
- R6: Links at or above the active count for the captured rate hold their data and clock outputs low.
- R7: The rate, bond and slice inputs are sampled only in the strobe cycle. Changes to them between strobes have no effect on the frame being sent.
- R8: Bond code c forms lanes of 2^c consecutive links, with code 0 meaning unbonded. The lane size is capped at the active link count.
- R9: A lane of K links owns the K*B consecutive slice bits that follow the lanes below it, MSB first. Lane bit j goes out on member link j mod K, in slot j div K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, 16 cycles per frame |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle frame boundary strobe |
| frame_slice | input | 16 | Data slice for the next frame |
| rate_sel | input | 2 | Per-link rate code |
| bond_sel | input | 2 | Lane bonding code |
| link_dout | output | 8 | Serial data per link |
| link_clk | output | 8 | Forwarded bit clock per link |

## Verification
The outputs are decoded from registered frame state. Each result therefore becomes visible one clock edge after the strobe edge that loads it, and then advances once per reference cycle. The bench raises the strobe at a falling edge, lets the next rising edge capture it, and samples at each of the following 16 falling edges. Sample k is compared with the expected value for phase k: the slot index is k divided by the slot length, and the clock level follows from k modulo the slot length. Strobes are issued back to back, so the next frame loads exactly at the edge where phase 15 ends. In the configuration-change test, the rate, bond and slice inputs are altered after sample 5, and the remaining samples must still match the values captured at the strobe.

// File: rtl/elink_tx_pkg.sv
package elink_tx_pkg;

    // phase counter width: 16 reference cycles per frame
    localparam int FRAME_PH_W = 4;

    typedef enum logic [1:0] {
        RATE_LOW   = 2'd0,
        RATE_MID   = 2'd1,
        RATE_HIGH  = 2'd2,
        RATE_ALIAS = 2'd3
    } rate_e;

    // the spare code falls back to the lowest rate
    function automatic logic [1:0] norm_rate(input logic [1:0] code);
        return (code == RATE_ALIAS) ? RATE_LOW : code;
    endfunction

endpackage

// File: rtl/elink_tx_frame_ctl.sv
module elink_tx_frame_ctl
    import elink_tx_pkg::*;
#(
    parameter int N_LINKS = 8,
    localparam int SLICE_W = 2 * N_LINKS,
    localparam int PH_W = FRAME_PH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_stb,
    input  logic [SLICE_W-1:0] frame_slice,
    input  logic [1:0]         rate_sel,
    input  logic [1:0]         bond_sel,
    output logic               run_o,
    output logic [PH_W-1:0]    phase_o,
    output logic [SLICE_W-1:0] slice_o,
    output logic [1:0]         rate_o,
    output logic [1:0]         bond_o
);

    typedef struct packed {
        logic               run;
        logic [PH_W-1:0]    phase;
        logic [SLICE_W-1:0] slice;
        logic [1:0]         rate;
        logic [1:0]         bond;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            st_d.run   = 1'b1;
            st_d.phase = '0;
            st_d.slice = frame_slice;
            st_d.rate  = norm_rate(rate_sel);
            st_d.bond  = bond_sel;
        end else if (st_q.run) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign phase_o = st_q.phase;
    assign slice_o = st_q.slice;
    assign rate_o  = st_q.rate;
    assign bond_o  = st_q.bond;

endmodule

// File: rtl/elink_tx_slot_map.sv
module elink_tx_slot_map
    import elink_tx_pkg::*;
#(
    parameter int N_LINKS = 8,
    localparam int SLICE_W = 2 * N_LINKS,
    localparam int PH_W = FRAME_PH_W,
    localparam int LINK_W = $clog2(N_LINKS),
    localparam int IDX_W = $clog2(SLICE_W),
    localparam int GW = IDX_W + 4
) (
    input  logic               run,
    input  logic [PH_W-1:0]    phase,
    input  logic [SLICE_W-1:0] slice,
    input  logic [1:0]         rate,
    input  logic [1:0]         bond,
    output logic [N_LINKS-1:0] act_o,
    output logic [N_LINKS-1:0] dout_o
);

    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
        logic [2:0]    act_log;
        logic [2:0]    kb;
        logic          act;
        logic [GW-1:0] slot;
        logic [GW-1:0] base;
        logic [GW-1:0] member;
        logic [GW-1:0] gidx;
        logic [GW-1:0] sidx;
        logic          bit_l;

        always_comb begin
            // log2 of the active link count at this rate
            act_log = 3'(LINK_W) - {1'b0, rate};
            // log2 of the lane size, capped at the active link count
            kb      = ({1'b0, bond} > act_log) ? act_log : {1'b0, bond};
            act     = (GW'(i) >> act_log) == '0;
            slot    = GW'(phase) >> (3'(PH_W - 1) - {1'b0, rate});
            base    = (GW'(i) >> kb) << kb;
            member  = GW'(i) & ((GW'(1) << kb) - GW'(1));
            gidx    = (base << (3'd1 + {1'b0, rate})) + (slot << kb) + member;
            sidx    = GW'(SLICE_W - 1) - gidx;
            bit_l   = run & act & slice[sidx[IDX_W-1:0]];
        end

        assign act_o[i]  = run & act;
        assign dout_o[i] = bit_l;
    end

endmodule

// File: rtl/elink_tx_clk_fwd.sv
module elink_tx_clk_fwd
    import elink_tx_pkg::*;
#(
    parameter int N_LINKS = 8,
    localparam int PH_W = FRAME_PH_W
) (
    input  logic [PH_W-1:0]    phase,
    input  logic [1:0]         rate,
    input  logic [N_LINKS-1:0] act,
    output logic [N_LINKS-1:0] clk_o
);

    logic [1:0] half_bit;
    logic       high_half;

    always_comb begin
        // the phase bit that marks the second half of a slot
        half_bit  = 2'(PH_W - 2) - rate;
        high_half = ~phase[half_bit];
    end

    for (genvar i = 0; i < N_LINKS; i++) begin : g_clk
        assign clk_o[i] = act[i] & high_half;
    end

endmodule

// File: rtl/elink_tx_group.sv
module elink_tx_group
    import elink_tx_pkg::*;
#(
    parameter int N_LINKS = 8,
    localparam int SLICE_W = 2 * N_LINKS,
    localparam int PH_W = FRAME_PH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_stb,
    input  logic [SLICE_W-1:0] frame_slice,
    input  logic [1:0]         rate_sel,
    input  logic [1:0]         bond_sel,
    output logic [N_LINKS-1:0] link_dout,
    output logic [N_LINKS-1:0] link_clk
);

    logic               run;
    logic [PH_W-1:0]    phase;
    logic [SLICE_W-1:0] slice;
    logic [1:0]         rate;
    logic [1:0]         bond;
    logic [N_LINKS-1:0] act;

    elink_tx_frame_ctl #(.N_LINKS(N_LINKS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .frame_slice (frame_slice),
        .rate_sel    (rate_sel),
        .bond_sel    (bond_sel),
        .run_o       (run),
        .phase_o     (phase),
        .slice_o     (slice),
        .rate_o      (rate),
        .bond_o      (bond)
    );

    elink_tx_slot_map #(.N_LINKS(N_LINKS)) u_map (
        .run    (run),
        .phase  (phase),
        .slice  (slice),
        .rate   (rate),
        .bond   (bond),
        .act_o  (act),
        .dout_o (link_dout)
    );

    elink_tx_clk_fwd #(.N_LINKS(N_LINKS)) u_clk (
        .phase (phase),
        .rate  (rate),
        .act   (act),
        .clk_o (link_clk)
    );

endmodule

// File: rtl/elink_tx_group_chk.sv
module elink_tx_group_chk #(
    parameter int N_LINKS = 8,
    localparam int SLICE_W = 2 * N_LINKS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_stb,
    input logic [SLICE_W-1:0] frame_slice,
    input logic [1:0]         rate_sel,
    input logic [1:0]         bond_sel,
    input logic [N_LINKS-1:0] link_dout,
    input logic [N_LINKS-1:0] link_clk
);

    logic               seen_q;
    logic [1:0]         rate_q;
    logic [N_LINKS:0]   top_bit;
    logic [N_LINKS-1:0] act_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            rate_q <= 2'd0;
        end else if (frame_stb) begin
            seen_q <= 1'b1;
            rate_q <= (rate_sel == 2'd3) ? 2'd0 : rate_sel;
        end
    end

    always_comb begin
        top_bit  = (N_LINKS + 1)'(1) << (N_LINKS >> rate_q);
        act_mask = N_LINKS'(top_bit - 1'b1);
    end

    p_quiet_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (link_dout == '0 && link_clk == '0));

    p_data_on_clk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_dout) |-> $rose(link_clk[0]));

    p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (link_dout[0] == $past(frame_slice[SLICE_W-1])));

    p_clk_high_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> link_clk[0]);

    p_inactive_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (((link_dout | link_clk) & ~act_mask) == '0));

endmodule

bind elink_tx_group elink_tx_group_chk #(.N_LINKS(N_LINKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb   (frame_stb),
    .frame_slice (frame_slice),
    .rate_sel    (rate_sel),
    .bond_sel    (bond_sel),
    .link_dout   (link_dout),
    .link_clk    (link_clk)
);

// File: tb/elink_tx_group_test.sv
`timescale 1ns/1ps
module elink_tx_group_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [15:0] frame_slice = '0;
    logic [1:0]  rate_sel = '0;
    logic [1:0]  bond_sel = '0;
    logic [7:0]  link_dout;
    logic [7:0]  link_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    elink_tx_group uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .frame_slice (frame_slice),
        .rate_sel    (rate_sel),
        .bond_sel    (bond_sel),
        .link_dout   (link_dout),
        .link_clk    (link_clk)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // R1: quiet outputs before any strobe
    task automatic test_reset_idle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 data idle", link_dout, 8'h00);
            chk("R1 clock idle", link_clk, 8'h00);
        end
    endtask

    // one frame: strobe now (at a falling edge), then check 16 samples
    task automatic run_frame(input logic [15:0] sl, input logic [1:0] rt,
                             input logic [1:0] bd, input bit disturb);
        logic expd [0:7][0:7];
        int rn, nact, bpl, lane, dur;
        logic [7:0] mask, exp_d, exp_c;
        string dtag;
        rn   = (rt == 2'd3) ? 0 : int'(rt);
        nact = 8 >> rn;
        bpl  = 16 / nact;
        lane = 1 << bd;
        if (lane > nact) lane = nact;
        dur  = 16 / bpl;
        mask = 8'((1 << nact) - 1);
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                expd[a][b] = 1'b0;
        // deal each lane's bits out round-robin over its members
        for (int ln = 0; ln < nact / lane; ln++)
            for (int j = 0; j < lane * bpl; j++)
                expd[ln * lane + (j % lane)][j / lane] = sl[15 - (ln * lane * bpl + j)];
        if (disturb)          dtag = "R7 R2 R3 data";
        else if ((1 << bd) > nact) dtag = "R8 R9 R2 R3 data";
        else if (bd != 0)     dtag = "R9 R2 R3 data";
        else                  dtag = "R4 R2 R3 data";

        frame_stb   = 1'b1;
        frame_slice = sl;
        rate_sel    = rt;
        bond_sel    = bd;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            frame_stb = 1'b0;
            exp_d = '0;
            for (int l = 0; l < nact; l++) exp_d[l] = expd[l][k / dur];
            exp_c = ((k % dur) < (dur / 2)) ? mask : 8'h00;
            chk(dtag, link_dout & mask, exp_d);
            chk("R5 clock", link_clk & mask, exp_c);
            chk("R6 inactive", (link_dout | link_clk) & ~mask, 8'h00);
            if (disturb && k == 5) begin
                frame_slice = ~sl;
                rate_sel    = rt + 2'd1;
                bond_sel    = bd ^ 2'd1;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_idle();
        run_frame(16'hA5C3, 2'd0, 2'd0, 1'b0);
        run_frame(16'h3C96, 2'd1, 2'd0, 1'b0);
        run_frame(16'hB2E1, 2'd2, 2'd0, 1'b0);
        run_frame(16'h5A0F, 2'd3, 2'd0, 1'b0);
        run_frame(16'hC3A5, 2'd0, 2'd1, 1'b0);
        run_frame(16'h9D27, 2'd1, 2'd2, 1'b0);
        run_frame(16'h71E8, 2'd0, 2'd3, 1'b0);
        run_frame(16'hE4B9, 2'd2, 2'd3, 1'b0);
        run_frame(16'h6C35, 2'd2, 2'd0, 1'b1);
        run_frame(16'h8F1D, 2'd1, 2'd1, 1'b0);
        run_frame(16'hFFFF, 2'd2, 2'd1, 1'b0);
        run_frame(16'h0001, 2'd0, 2'd0, 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule